// File: doc/BRIEF.md
# Transfer-Controller Activation Enable Register File

This block holds the per-source permission bits that decide which interrupt sources may start a data transfer controller, together with the register through which software requests a transfer itself. It has six 8-bit enable registers, one bit for each of 48 activating sources, and one software activation register that holds a request flag and a 7-bit vector number. A CPU reads and writes all seven registers over a small synchronous bus. The transfer engine reads the live enable bits and the software request directly from output ports.

The transfer engine reports each finished transfer with a one-cycle strobe. The strobe carries the 6-bit source index, the source's disable-after-transfer mode bit and a flag. The flag says that the source's 16-bit block counter has run out: the counter covers 1 to 65,536 transfers and ends at 0x0000. From these inputs the block clears the matching enable bit by hardware. The software request flag follows a read-before-clear discipline. Software can always set it, but a 0 written to it takes effect only after a CPU read has returned it as 1.

Top module: `xfer_act_regs`

## Requirements
- R1: Addresses 0 to 5 select enable registers A to F. A write stores all 8 bits and a read returns them on `cpu_rdata` in the same cycle. Bit b of register r drives `act_en[8*r+b]`.
- R2: An active-low `rst_n`, or a high `standby` sampled at a clock edge, sets every enable register, the request flag, the vector and the read-seen state to 0.
- R3: A completion strobe with the disable-after-transfer bit set clears the addressed enable bit at the next clock edge.
- R4: A completion strobe with the count-exhausted flag set clears the addressed enable bit at the next clock edge.
- R5: A completion strobe with both the disable-after-transfer bit and the count-exhausted flag at 0 leaves every enable bit unchanged.
- R6: Bits 5:3 of `done_src` select the register and bits 2:0 select the bit. A register select of 6 or 7 changes no enable bit.
- R7: If a CPU write and a hardware clear reach the same enable bit in one cycle, that bit ends at 0. The other bits of the register take the written data.
- R8: Address 6 holds the software register, with the request flag in bit 7 and the vector in bits 6:0. A write always loads the vector, and a write with bit 7 set sets the flag. `sw_req` and `sw_vec` show the register.
- R9: A write of 0 to bit 7 clears the flag only if a CPU read of address 6 returned the flag as 1 after the last write to address 6. Otherwise the flag keeps its value.
- R10: Every write to address 6 disarms the read-seen state, so each clear needs a fresh read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous clear of all state |
| cpu_addr | input | 3 | Register address (0-5 enables, 6 software register) |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read strobe (arms the read-seen state) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr`, combinational |
| done_valid | input | 1 | Transfer-completion strobe |
| done_src | input | 6 | Source index of the completed transfer |
| done_disel | input | 1 | Disable-after-transfer mode bit of that source |
| done_last | input | 1 | Source's transfer count has reached zero |
| act_en | output | 48 | Live enable bit per source |
| sw_req | output | 1 | Software activation request flag |
| sw_vec | output | 7 | Software activation vector number |

## Verification
Every register update, whether it comes from a write, a completion strobe or standby, shows on `act_en`, `sw_req` and `sw_vec` one clock edge after the stimulus. `cpu_rdata` follows the current register contents with no delay. The bench drives each stimulus for exactly one cycle starting at a falling edge and releases it at the next falling edge, after the single rising edge that registers it. It then places the address to check and samples one time unit later, so each result is read one edge after its stimulus. Reads of the software register go through `sw_req`/`sw_vec` and not through a read strobe, so a check never arms the read-seen state it is testing.

// File: rtl/xar_pkg.sv
package xar_pkg;

    localparam int XAR_NUM_REGS = 6;
    localparam int XAR_REG_W    = 8;
    localparam int XAR_VEC_W    = XAR_REG_W - 1;
    localparam int XAR_ADDR_W   = 3;
    localparam int XAR_SRC_W    = XAR_ADDR_W + $clog2(XAR_REG_W);

    // state of the software activation register
    typedef struct packed {
        logic                 flag;
        logic [XAR_VEC_W-1:0] vec;
        logic                 seen;
    } sw_state_t;

endpackage

// File: rtl/xar_enable_bank.sv
module xar_enable_bank #(
    parameter int NUM_REGS = 6,
    parameter int REG_W    = 8,
    parameter int ADDR_W   = 3,
    parameter int SRC_W    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       standby,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_sel,
    input  logic [REG_W-1:0]           wr_data,
    input  logic                       done_valid,
    input  logic [SRC_W-1:0]           done_src,
    input  logic                       done_disel,
    input  logic                       done_last,
    output logic [NUM_REGS*REG_W-1:0]  en_q
);

    localparam int TOTAL = NUM_REGS * REG_W;
    localparam int BIT_W = $clog2(REG_W);
    localparam int SEL_W = SRC_W - BIT_W;
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_REGS - 1);

    typedef struct packed {
        logic [TOTAL-1:0] en;
    } bank_t;

    bank_t state_d, state_q;
    logic [TOTAL-1:0] clr_vec;
    logic             src_ok;

    assign src_ok = done_src[SRC_W-1:BIT_W] <= LAST_SEL;

    always_comb begin
        clr_vec = '0;
        if (done_valid && src_ok && (done_disel || done_last)) begin
            clr_vec[done_src] = 1'b1;
        end
        state_d = state_q;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (wr_en && wr_sel == ADDR_W'(r)) begin
                state_d.en[r*REG_W +: REG_W] = wr_data;
            end
        end
        state_d.en = state_d.en & ~clr_vec;
        if (standby) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en_q = state_q.en;

    // R3 R4 R7
    property p_hw_clear;
        @(posedge clk) disable iff (!rst_n)
        (done_valid && src_ok && (done_disel || done_last))
            |=> !en_q[$past(done_src)];
    endproperty
    hw_clear_chk: assert property (p_hw_clear);

    // R5
    property p_hold;
        @(posedge clk) disable iff (!rst_n)
        (done_valid && !done_disel && !done_last && !wr_en && !standby)
            |=> $stable(en_q);
    endproperty
    hold_chk: assert property (p_hold);

    // R6
    property p_ignore_sel;
        @(posedge clk) disable iff (!rst_n)
        (done_valid && !src_ok && !wr_en && !standby) |=> $stable(en_q);
    endproperty
    ignore_sel_chk: assert property (p_ignore_sel);

    // R2
    property p_standby;
        @(posedge clk) disable iff (!rst_n)
        standby |=> (en_q == '0);
    endproperty
    standby_bank_chk: assert property (p_standby);

endmodule

// File: rtl/xar_swact_reg.sv
module xar_swact_reg
    import xar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 standby,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [XAR_REG_W-1:0] wr_data,
    output logic                 flag,
    output logic [XAR_VEC_W-1:0] vec
);

    sw_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.vec = wr_data[XAR_VEC_W-1:0];
            if (wr_data[XAR_REG_W-1]) begin
                state_d.flag = 1'b1;
            end else if (state_q.seen) begin
                state_d.flag = 1'b0;
            end
            state_d.seen = 1'b0;
        end else if (rd_en && state_q.flag) begin
            state_d.seen = 1'b1;
        end
        if (standby) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag = state_q.flag;
    assign vec  = state_q.vec;

    // R8
    property p_set;
        @(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[XAR_REG_W-1] && !standby) |=> flag;
    endproperty
    flag_set_chk: assert property (p_set);

    // R9
    property p_keep;
        @(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[XAR_REG_W-1] && !state_q.seen && !standby)
            |=> (flag == $past(flag));
    endproperty
    flag_keep_chk: assert property (p_keep);

    // R10
    property p_disarm;
        @(posedge clk) disable iff (!rst_n)
        wr_en |=> !state_q.seen;
    endproperty
    seen_disarm_chk: assert property (p_disarm);

endmodule

// File: rtl/xar_read_mux.sv
module xar_read_mux #(
    parameter int NUM_REGS = 6,
    parameter int REG_W    = 8,
    parameter int ADDR_W   = 3
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_REGS*REG_W-1:0] en_bank,
    input  logic [REG_W-1:0]          sw_word,
    output logic [REG_W-1:0]          rdata
);

    localparam logic [ADDR_W-1:0] SW_ADDR = ADDR_W'(NUM_REGS);

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr == ADDR_W'(r)) begin
                rdata = en_bank[r*REG_W +: REG_W];
            end
        end
        if (addr == SW_ADDR) begin
            rdata = sw_word;
        end
    end

endmodule

// File: rtl/xfer_act_regs.sv
module xfer_act_regs
    import xar_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              standby,
    input  logic [XAR_ADDR_W-1:0]             cpu_addr,
    input  logic                              cpu_we,
    input  logic                              cpu_re,
    input  logic [XAR_REG_W-1:0]              cpu_wdata,
    output logic [XAR_REG_W-1:0]              cpu_rdata,
    input  logic                              done_valid,
    input  logic [XAR_SRC_W-1:0]              done_src,
    input  logic                              done_disel,
    input  logic                              done_last,
    output logic [XAR_NUM_REGS*XAR_REG_W-1:0] act_en,
    output logic                              sw_req,
    output logic [XAR_VEC_W-1:0]              sw_vec
);

    localparam logic [XAR_ADDR_W-1:0] SW_ADDR = XAR_ADDR_W'(XAR_NUM_REGS);

    logic sw_hit, sw_wr, sw_rd;

    assign sw_hit = (cpu_addr == SW_ADDR);
    assign sw_wr  = cpu_we && sw_hit;
    assign sw_rd  = cpu_re && !cpu_we && sw_hit;

    xar_enable_bank #(
        .NUM_REGS (XAR_NUM_REGS),
        .REG_W    (XAR_REG_W),
        .ADDR_W   (XAR_ADDR_W),
        .SRC_W    (XAR_SRC_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .wr_en      (cpu_we),
        .wr_sel     (cpu_addr),
        .wr_data    (cpu_wdata),
        .done_valid (done_valid),
        .done_src   (done_src),
        .done_disel (done_disel),
        .done_last  (done_last),
        .en_q       (act_en)
    );

    xar_swact_reg u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .wr_en   (sw_wr),
        .rd_en   (sw_rd),
        .wr_data (cpu_wdata),
        .flag    (sw_req),
        .vec     (sw_vec)
    );

    xar_read_mux #(
        .NUM_REGS (XAR_NUM_REGS),
        .REG_W    (XAR_REG_W),
        .ADDR_W   (XAR_ADDR_W)
    ) u_rmux (
        .addr    (cpu_addr),
        .en_bank (act_en),
        .sw_word ({sw_req, sw_vec}),
        .rdata   (cpu_rdata)
    );

    // R2
    property p_standby_sw;
        @(posedge clk) disable iff (!rst_n)
        standby |=> (!sw_req && sw_vec == '0);
    endproperty
    standby_sw_chk: assert property (p_standby_sw);

endmodule

// File: tb/xfer_act_regs_tb.sv
`timescale 1ns/1ps
module xfer_act_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_re = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        done_valid = 1'b0;
    logic [5:0]  done_src = '0;
    logic        done_disel = 1'b0;
    logic        done_last = 1'b0;
    logic [47:0] act_en;
    logic        sw_req;
    logic [6:0]  sw_vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xfer_act_regs u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .done_valid(done_valid), .done_src(done_src),
        .done_disel(done_disel), .done_last(done_last),
        .act_en(act_en), .sw_req(sw_req), .sw_vec(sw_vec)
    );

    // op: 0 write, 1 read, 2 completion (data = source index)
    typedef struct packed {
        logic [1:0] op;
        logic [2:0] addr;
        logic [7:0] data;
        logic       disel;
        logic       last;
        logic [2:0] caddr;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 8'hA5, 1'b0, 1'b0, 3'd0, 8'hA5, 4'd1},  // R1
        '{2'd0, 3'd5, 8'h3C, 1'b0, 1'b0, 3'd5, 8'h3C, 4'd1},  // R1
        '{2'd2, 3'd0, 8'h00, 1'b1, 1'b0, 3'd0, 8'hA4, 4'd3},  // R3
        '{2'd2, 3'd0, 8'h02, 1'b0, 1'b1, 3'd0, 8'hA0, 4'd4},  // R4
        '{2'd2, 3'd0, 8'h05, 1'b0, 1'b0, 3'd0, 8'hA0, 4'd5},  // R5
        '{2'd2, 3'd0, 8'h2A, 1'b1, 1'b0, 3'd5, 8'h38, 4'd6},  // R6
        '{2'd2, 3'd0, 8'h30, 1'b1, 1'b0, 3'd5, 8'h38, 4'd6},  // R6
        '{2'd2, 3'd0, 8'h3F, 1'b0, 1'b1, 3'd0, 8'hA0, 4'd6},  // R6
        '{2'd0, 3'd6, 8'h85, 1'b0, 1'b0, 3'd6, 8'h85, 4'd8},  // R8
        '{2'd0, 3'd6, 8'h03, 1'b0, 1'b0, 3'd6, 8'h83, 4'd9},  // R9
        '{2'd1, 3'd6, 8'h00, 1'b0, 1'b0, 3'd6, 8'h83, 4'd9},  // R9
        '{2'd0, 3'd6, 8'h11, 1'b0, 1'b0, 3'd6, 8'h11, 4'd9},  // R9
        '{2'd0, 3'd6, 8'h80, 1'b0, 1'b0, 3'd6, 8'h80, 4'd8},  // R8
        '{2'd1, 3'd6, 8'h00, 1'b0, 1'b0, 3'd6, 8'h80, 4'd10}, // R10
        '{2'd0, 3'd6, 8'h82, 1'b0, 1'b0, 3'd6, 8'h82, 4'd10}, // R10
        '{2'd0, 3'd6, 8'h00, 1'b0, 1'b0, 3'd6, 8'h80, 4'd10}, // R10
        '{2'd1, 3'd6, 8'h00, 1'b0, 1'b0, 3'd6, 8'h80, 4'd9},  // R9
        '{2'd0, 3'd6, 8'h05, 1'b0, 1'b0, 3'd6, 8'h05, 4'd9}   // R9
    };

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one-cycle stimulus: drive at a falling edge, release at the next
    task automatic apply(input logic [1:0] op, input logic [2:0] addr, input logic [7:0] data,
                         input logic disel, input logic last);
        @(negedge clk);
        cpu_addr = addr;
        case (op)
            2'd0: begin cpu_we = 1'b1; cpu_wdata = data; end
            2'd1: cpu_re = 1'b1;
            default: begin
                done_valid = 1'b1; done_src = data[5:0];
                done_disel = disel; done_last = last;
            end
        endcase
        @(negedge clk);
        cpu_we = 1'b0; cpu_re = 1'b0; done_valid = 1'b0;
        done_disel = 1'b0; done_last = 1'b0;
    endtask

    function automatic logic [7:0] peek_word(input logic [2:0] a);
        if (a == 3'd6) return {sw_req, sw_vec};
        return cpu_rdata;
    endfunction

    task automatic check_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
        cpu_addr = a;
        #1;
        check(tag, {40'h0, peek_word(a)}, {40'h0, exp});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 reset act_en", act_en, 48'h0);
        for (int a = 0; a < 7; a++) check_reg("R2 reset reg", 3'(a), 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].disel, VECS[i].last);
            check_reg($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].caddr, VECS[i].exp);
        end

        // R1: act_en mirrors registers A and F
        check("R1 act_en F", {40'h0, act_en[47:40]}, 48'h38);
        check("R1 act_en A", {40'h0, act_en[7:0]}, 48'hA0);

        // R7: write and hardware clear on the same bit in one cycle
        @(negedge clk);
        cpu_addr = 3'd0; cpu_we = 1'b1; cpu_wdata = 8'hFF;
        done_valid = 1'b1; done_src = 6'h03; done_disel = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0; done_valid = 1'b0; done_disel = 1'b0;
        check_reg("R7 collision", 3'd0, 8'hF7);

        // R2: standby clears everything
        apply(2'd0, 3'd6, 8'hC4, 1'b0, 1'b0);
        check_reg("R8 before standby", 3'd6, 8'hC4);
        @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
        #1;
        check("R2 standby act_en", act_en, 48'h0);
        check("R2 standby sw", {40'h0, sw_req, sw_vec}, 48'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule